// File: doc/BRIEF.md
# Trace Capture Qualifier

This block sits beside a memory-bus command stream and decides, one command at a time, whether each command is recorded in a trace memory. Each incoming command carries a valid strobe, a 6-bit opcode, a 5-bit source id, a 5-bit destination id and a 38-bit address. The block does not store captured entries. It raises a single-cycle capture strobe that the trace storage uses as its write enable.

Three match units judge every command: a filter, a start trigger and a stop trigger. Each unit holds five fields: an opcode bitmask, a source bitmask, a destination bitmask, an address compare value and an address mask. The fields are loaded one at a time through a register write port.

With triggers off, every command that matches the filter is recorded. With triggers on, recording is confined to a window. The window opens on a start-trigger hit and closes after a stop-trigger hit. Inside the window, a command is recorded when it matches any of the three units, so the start and stop commands themselves are recorded.

Top module: `trace_qualifier`

## Requirements
- R1: While reset is high, and on the cycle after it, the capture strobe is low and the trigger window is closed. Reset clears every configuration field to zero, so no command is captured until the units are loaded.
- R2: A unit's opcode test passes when bit `op` of its 64-bit opcode mask is set.
- R3: A unit's source test passes when bit `src` of its 32-bit source mask is set. Its destination test passes when bit `dst` of its 32-bit destination mask is set.
- R4: A unit's address test passes when `((addr ^ compare) & mask) == 0` over all 38 address bits.
- R5: A unit matches only when all four of its tests pass. A single failing test blocks the match.
- R6: With `trig_en` low, a valid command is captured exactly when it matches the filter. Trigger matches have no effect in this mode.
- R7: With `trig_en` high and the window closed, a command that does not hit the start trigger is not captured, even when it matches the filter.
- R8: A start-trigger hit is captured and opens the window. While the window is open, commands matching the filter are captured.
- R9: A stop-trigger hit inside the window is captured, and the window is closed for the following commands.
- R10: Opcode 0 (idle) and opcode 63 (I/O response) are never captured, even when every mask is all ones. Such commands also never open or close the window.
- R11: The capture strobe is registered. It goes high in the cycle after the valid command and lasts exactly one cycle. No strobe follows a cycle in which `cmd_vld` is low.
- R12: A configuration write uses `cfg_unit` to select the unit (0 filter, 1 start, 2 stop) and `cfg_field` to select the field:
  - 0: opcode mask, from `cfg_data[63:0]`
  - 1: source mask, from `cfg_data[31:0]`
  - 2: destination mask, from `cfg_data[31:0]`
  - 3: address compare, from `cfg_data[37:0]`
  - 4: address mask, from `cfg_data[37:0]`

  The new value governs commands from the next cycle on.
- R13: Driving `trig_en` low closes the window. After triggers are re-enabled, a new start hit is needed before anything is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_en | input | 1 | Enables the start/stop trigger window |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_unit | input | 2 | Unit select: 0 filter, 1 start, 2 stop |
| cfg_field | input | 3 | Field select (see R12) |
| cfg_data | input | 64 | Configuration write data |
| cmd_vld | input | 1 | Command valid |
| cmd_op | input | 6 | Command opcode |
| cmd_src | input | 5 | Source id |
| cmd_dst | input | 5 | Destination id |
| cmd_addr | input | 38 | Command address |
| capture | output | 1 | One-cycle strobe: record the previous cycle's command |

## Verification
The only internal state is the trigger window bit and the configuration fields, and both show up one cycle later on `capture`. A window bit that stays open after a stop hit shows as a spurious strobe on the next filter match. A window bit that fails to open shows as a missing strobe on the start command itself. A wrong configuration field shows as a strobe that is missing or extra on the first command that probes the affected mask bit, so the directed commands target single bits at both ends of each mask.

// File: rtl/trq_pkg.sv
package trq_pkg;
  localparam int OP_W      = 6;
  localparam int ID_W      = 5;
  localparam int ADDR_W    = 38;
  localparam int CFG_W     = 64;
  localparam int NUM_OPS   = 1 << OP_W;
  localparam int NUM_IDS   = 1 << ID_W;
  localparam int NUM_UNITS = 3;
  localparam int UNIT_W    = 2;
  localparam int FLD_W     = 3;

  localparam int U_FILT  = 0;
  localparam int U_START = 1;
  localparam int U_STOP  = 2;

  localparam logic [OP_W-1:0] OP_IDLE  = '0;
  localparam logic [OP_W-1:0] OP_IORSP = '1;

  typedef enum logic [FLD_W-1:0] {
    FLD_OPS = 3'd0,
    FLD_SRC = 3'd1,
    FLD_DST = 3'd2,
    FLD_CMP = 3'd3,
    FLD_MSK = 3'd4
  } cfg_field_e;

  typedef struct packed {
    logic [NUM_OPS-1:0] op_mask;
    logic [NUM_IDS-1:0] src_mask;
    logic [NUM_IDS-1:0] dst_mask;
    logic [ADDR_W-1:0]  addr_cmp;
    logic [ADDR_W-1:0]  addr_msk;
  } unit_cfg_t;
endpackage

// File: rtl/trq_cfg_bank.sv
module trq_cfg_bank
  import trq_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [UNIT_W-1:0]                cfg_unit,
  input  logic [FLD_W-1:0]                 cfg_field,
  input  logic [CFG_W-1:0]                 cfg_data,
  output unit_cfg_t [NUM_UNITS-1:0]        cfg_q
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic sel;
    assign sel = cfg_we && (cfg_unit == UNIT_W'(u));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[u] <= '0;
      end else if (sel) begin
        case (cfg_field)
          FLD_OPS: cfg_q[u].op_mask  <= cfg_data[NUM_OPS-1:0];
          FLD_SRC: cfg_q[u].src_mask <= cfg_data[NUM_IDS-1:0];
          FLD_DST: cfg_q[u].dst_mask <= cfg_data[NUM_IDS-1:0];
          FLD_CMP: cfg_q[u].addr_cmp <= cfg_data[ADDR_W-1:0];
          FLD_MSK: cfg_q[u].addr_msk <= cfg_data[ADDR_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/trq_match_unit.sv
module trq_match_unit
  import trq_pkg::*;
(
  input  unit_cfg_t         cfg,
  input  logic [OP_W-1:0]   op,
  input  logic [ID_W-1:0]   src,
  input  logic [ID_W-1:0]   dst,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic op_ok, src_ok, dst_ok, addr_ok;

  always_comb begin
    op_ok   = cfg.op_mask[op];
    src_ok  = cfg.src_mask[src];
    dst_ok  = cfg.dst_mask[dst];
    addr_ok = ((addr ^ cfg.addr_cmp) & cfg.addr_msk) == '0;
    hit     = op_ok && src_ok && dst_ok && addr_ok;
  end
endmodule

// File: rtl/trq_window.sv
module trq_window (
  input  logic clk,
  input  logic rst,
  input  logic trig_en,
  input  logic f_hit,
  input  logic s_hit,
  input  logic t_hit,
  output logic take,
  output logic win_q
);
  logic in_win;

  always_comb begin
    in_win = win_q || s_hit;
    if (trig_en) take = in_win && (f_hit || s_hit || t_hit);
    else         take = f_hit;
  end

  always_ff @(posedge clk) begin
    if (rst || !trig_en) win_q <= 1'b0;
    else                 win_q <= in_win && !t_hit;
  end
endmodule

// File: rtl/trace_qualifier.sv
module trace_qualifier
  import trq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_en,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_unit,
  input  logic [2:0]        cfg_field,
  input  logic [63:0]       cfg_data,
  input  logic              cmd_vld,
  input  logic [5:0]        cmd_op,
  input  logic [4:0]        cmd_src,
  input  logic [4:0]        cmd_dst,
  input  logic [37:0]       cmd_addr,
  output logic              capture
);
  unit_cfg_t [NUM_UNITS-1:0] cfg_q;
  logic [NUM_UNITS-1:0]      unit_hit;
  logic                      eligible;
  logic                      take;
  logic                      win_q;
  logic                      capture_q;

  trq_cfg_bank u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_unit  (cfg_unit),
    .cfg_field (cfg_field),
    .cfg_data  (cfg_data),
    .cfg_q     (cfg_q)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_match
    trq_match_unit u_match (
      .cfg  (cfg_q[u]),
      .op   (cmd_op),
      .src  (cmd_src),
      .dst  (cmd_dst),
      .addr (cmd_addr),
      .hit  (unit_hit[u])
    );
  end

  assign eligible = cmd_vld && (cmd_op != OP_IDLE) && (cmd_op != OP_IORSP);

  trq_window u_win (
    .clk     (clk),
    .rst     (rst),
    .trig_en (trig_en),
    .f_hit   (eligible && unit_hit[U_FILT]),
    .s_hit   (eligible && unit_hit[U_START]),
    .t_hit   (eligible && unit_hit[U_STOP]),
    .take    (take),
    .win_q   (win_q)
  );

  always_ff @(posedge clk) begin
    if (rst) capture_q <= 1'b0;
    else     capture_q <= take;
  end

  assign capture = capture_q;
endmodule

// File: rtl/trace_qualifier_chk.sv
module trace_qualifier_chk
  import trq_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 trig_en,
  input logic                 cmd_vld,
  input logic [OP_W-1:0]      cmd_op,
  input logic [NUM_UNITS-1:0] unit_hit,
  input logic                 win_q,
  input logic                 capture
);
  logic elig;
  assign elig = cmd_vld && (cmd_op != OP_IDLE) && (cmd_op != OP_IORSP);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!capture && !win_q));

  p_filter_only_r6: assert property (@(posedge clk) disable iff (rst)
    (!trig_en && elig) |=> (capture == $past(unit_hit[U_FILT])));

  p_closed_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (trig_en && !win_q && !unit_hit[U_START]) |=> !capture);

  p_start_opens_r8: assert property (@(posedge clk) disable iff (rst)
    (trig_en && elig && unit_hit[U_START] && !unit_hit[U_STOP]) |=> (capture && win_q));

  p_stop_closes_r9: assert property (@(posedge clk) disable iff (rst)
    (trig_en && elig && unit_hit[U_STOP] && (win_q || unit_hit[U_START]))
      |=> (capture && !win_q));

  p_excluded_op_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && !elig) |=> (!capture && (win_q == $past(win_q) || !$past(trig_en))));

  p_no_valid_r11: assert property (@(posedge clk) disable iff (rst)
    !cmd_vld |=> !capture);

  p_disable_closes_r13: assert property (@(posedge clk) disable iff (rst)
    !trig_en |=> !win_q);
endmodule

bind trace_qualifier trace_qualifier_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .trig_en  (trig_en),
  .cmd_vld  (cmd_vld),
  .cmd_op   (cmd_op),
  .unit_hit (unit_hit),
  .win_q    (win_q),
  .capture  (capture)
);

// File: tb/test_trace_qualifier.sv
module test_trace_qualifier;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_unit = '0;
  logic [2:0]  cfg_field = '0;
  logic [63:0] cfg_data = '0;
  logic        cmd_vld = 1'b0;
  logic [5:0]  cmd_op = '0;
  logic [4:0]  cmd_src = '0;
  logic [4:0]  cmd_dst = '0;
  logic [37:0] cmd_addr = '0;
  logic        capture;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trace_qualifier i_trace_qualifier (
    .clk(clk), .rst(rst), .trig_en(trig_en),
    .cfg_we(cfg_we), .cfg_unit(cfg_unit), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
    .cmd_addr(cmd_addr), .capture(capture)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: capture actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wcfg(input int unit, input int field, input logic [63:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_unit = 2'(unit); cfg_field = 3'(field); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_unit(input int unit, input logic [63:0] ops, input logic [31:0] src,
                          input logic [31:0] dst, input logic [37:0] cmp, input logic [37:0] msk);
    wcfg(unit, 0, ops);
    wcfg(unit, 1, {32'd0, src});
    wcfg(unit, 2, {32'd0, dst});
    wcfg(unit, 3, {26'd0, cmp});
    wcfg(unit, 4, {26'd0, msk});
  endtask

  // one command, then one idle cycle; strobe sampled one cycle after the command
  task automatic send(input logic [5:0] op, input logic [4:0] src, input logic [4:0] dst,
                      input logic [37:0] addr, input logic exp, input string tag);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_op = op; cmd_src = src; cmd_dst = dst; cmd_addr = addr;
    @(negedge clk);
    cmd_vld = 1'b0;
    check(capture, exp, tag);
  endtask

  task automatic t_reset;
    check(capture, 1'b0, "R1 during reset");
    @(negedge clk); rst = 1'b0;
    check(capture, 1'b0, "R1 after reset");
    send(6'd1, 5'd0, 5'd0, 38'd0, 1'b0, "R1 cleared config captures nothing");
  endtask

  task automatic t_op_mask;
    set_unit(0, 64'h4000_0000_0000_0020, '1, '1, '0, '0);
    send(6'd5,  5'd1, 5'd1, 38'd0, 1'b1, "R2 op bit 5 set");
    send(6'd6,  5'd1, 5'd1, 38'd0, 1'b0, "R2 op bit 6 clear");
    send(6'd62, 5'd1, 5'd1, 38'd0, 1'b1, "R2 op bit 62 set");
  endtask

  task automatic t_ids;
    set_unit(0, '1, 32'h0000_0008, 32'h8000_0000, '0, '0);
    send(6'd7, 5'd3,  5'd31, 38'd0, 1'b1, "R3 src 3 dst 31 pass");
    send(6'd7, 5'd4,  5'd31, 38'd0, 1'b0, "R3 src 4 blocked");
    send(6'd7, 5'd3,  5'd0,  38'd0, 1'b0, "R3 dst 0 blocked");
  endtask

  task automatic t_addr;
    set_unit(0, '1, '1, '1, 38'h12_3456_0000, 38'h3F_FFFF_0000);
    send(6'd9, 5'd0, 5'd0, 38'h12_3456_ABCD, 1'b1, "R4 masked low bits ignored");
    send(6'd9, 5'd0, 5'd0, 38'h13_3456_0000, 1'b0, "R4 bit 32 differs");
    send(6'd9, 5'd0, 5'd0, 38'h32_3456_0000, 1'b0, "R4 bit 37 differs");
    wcfg(0, 1, 64'h0000_0001);
    send(6'd9, 5'd1, 5'd0, 38'h12_3456_0000, 1'b0, "R5 only source test fails");
    send(6'd9, 5'd0, 5'd0, 38'h12_3456_0000, 1'b1, "R5 all four tests pass");
  endtask

  task automatic t_excluded;
    set_unit(0, '1, '1, '1, '0, '0);
    send(6'd0,  5'd2, 5'd2, 38'd5, 1'b0, "R10 idle opcode 0");
    send(6'd63, 5'd2, 5'd2, 38'd5, 1'b0, "R10 io response opcode 63");
    send(6'd1,  5'd2, 5'd2, 38'd5, 1'b1, "R10 ordinary opcode 1");
  endtask

  task automatic t_latency;
    @(negedge clk);
    cmd_vld = 1'b1; cmd_op = 6'd2;
    #1 check(capture, 1'b0, "R11 no strobe in command cycle");
    @(negedge clk); cmd_vld = 1'b0; cmd_op = 6'd0;
    check(capture, 1'b1, "R11 strobe one cycle later");
    @(negedge clk);
    check(capture, 1'b0, "R11 strobe lasts one cycle");
    cmd_op = 6'd2;
    @(negedge clk);
    check(capture, 1'b0, "R11 matching opcode without valid");
  endtask

  task automatic t_window;
    set_unit(0, 64'h1 << 10, '1, '1, '0, '0);
    set_unit(1, 64'h1 << 20, '1, '1, '0, '0);
    set_unit(2, 64'h1 << 30, '1, '1, '0, '0);
    @(negedge clk); trig_en = 1'b1;
    send(6'd10, 5'd0, 5'd0, 38'd0, 1'b0, "R7 filter match before start");
    send(6'd30, 5'd0, 5'd0, 38'd0, 1'b0, "R7 stop before start");
    send(6'd0,  5'd0, 5'd0, 38'd0, 1'b0, "R10 idle in window test");
    send(6'd20, 5'd0, 5'd0, 38'd0, 1'b1, "R8 start command captured");
    send(6'd10, 5'd0, 5'd0, 38'd0, 1'b1, "R8 filter match in window");
    send(6'd5,  5'd0, 5'd0, 38'd0, 1'b0, "R8 no unit match in window");
    send(6'd30, 5'd0, 5'd0, 38'd0, 1'b1, "R9 stop command captured");
    send(6'd10, 5'd0, 5'd0, 38'd0, 1'b0, "R9 filter match after stop");
  endtask

  task automatic t_disable;
    send(6'd20, 5'd0, 5'd0, 38'd0, 1'b1, "R8 reopen window");
    @(negedge clk); trig_en = 1'b0;
    send(6'd10, 5'd0, 5'd0, 38'd0, 1'b1, "R6 filter match, triggers off");
    send(6'd20, 5'd0, 5'd0, 38'd0, 1'b0, "R6 start hit ignored, triggers off");
    @(negedge clk); trig_en = 1'b1;
    send(6'd10, 5'd0, 5'd0, 38'd0, 1'b0, "R13 window closed by disable");
    wcfg(1, 0, 64'h1 << 11);
    send(6'd11, 5'd0, 5'd0, 38'd0, 1'b1, "R12 rewritten start mask");
    send(6'd20, 5'd0, 5'd0, 38'd0, 1'b0, "R12 old start opcode unmatched");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_op_mask();
    t_ids();
    t_addr();
    t_excluded();
    t_latency();
    t_window();
    t_disable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule